// File: doc/BRIEF.md
# Board Control Register Block

A 32-bit slave that answers in a 4 KB address window. It holds the control state of a small evaluation board: two user LEDs, a general-purpose control word, a placeholder for push buttons, and three time bases. The host sees a plain single-cycle bus. `bus_valid` with `bus_write` high stores `bus_wdata` at the clock edge. `bus_valid` with `bus_write` low returns read data on `bus_rdata` in the same cycle. Only aligned 32-bit words are accessed and the byte order is little-endian.

The time bases live in their own submodules. Two free-running seconds counters advance once and one hundred times per second of the system clock `CLK_HZ`. A prescaled event counter is driven by a reload down-counter that is clocked at `PRESC_HZ`. Software can load and read any of these counters. Unmapped offsets read as zero and swallow writes silently.

Top module: `brd_ctrl_regs`

## Requirements
- R1: The word offsets are fixed as follows. LED 0x00, button 0x08, slow (1 Hz) count 0x10, fast (100 Hz) count 0x14, event count 0x18, reload value 0x1C, down-counter 0x20, control word 0x4C. Address bits [1:0] are ignored.
- R2: A write to LED keeps only `bus_wdata[1:0]`. From the next cycle on, `led_o[0]` equals bit 0 and `led_o[1]` equals bit 1, both active high. The register reads back the stored 2 bits zero-extended.
- R3: The button offset always reads zero, and a write to it changes nothing.
- R4: The control word stores all 32 bits written and returns them on read, with no other effect.
- R5: A read of any unmapped offset in the window returns zero. A write to one leaves every register and both LEDs unchanged.
- R6: Reset clears LED, control word, reload value, down-counter, event count and both seconds counters to zero.
- R7: The slow count rises by one every `CLK_HZ` cycles and the fast count every `CLK_HZ/100` cycles. A write loads the value and restarts the interval, so the value plus one appears exactly one interval after the write edge.
- R8: On each prescale tick, a nonzero down-counter decrements. A zero down-counter instead reloads from the reload value and the event count rises by one.
- R9: With a reload value of zero, the down-counter stays at zero and the event count rises on every prescale tick.
- R10: A write to the event count or the down-counter takes effect at the next edge and overrides that edge's tick update of the same register. Reads return the current register value in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Access strobe for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the read strobe |
| led_o | output | 2 | User LED drives, active high |

## Verification
The bench builds the block with `CLK_HZ` = 1600 and `PRESC_HZ` = 1600. This gives a prescale tick on every clock, a fast interval of 16 cycles and a slow interval of 1600 cycles. With a tick every cycle, each down-counter step, reload and event increment can be predicted edge by edge. The fast interval gives two complete rollovers in a few dozen cycles, and the slow one fits a full boundary check well inside the run length.

// File: rtl/brd_ctrl_pkg.sv
package brd_ctrl_pkg;

  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LED_N  = 2;
  localparam int unsigned WORD_W = ADDR_W - 2;

  localparam logic [WORD_W-1:0] WOFS_LED    = WORD_W'(32'h00 >> 2);
  localparam logic [WORD_W-1:0] WOFS_BTN    = WORD_W'(32'h08 >> 2);
  localparam logic [WORD_W-1:0] WOFS_SLOW   = WORD_W'(32'h10 >> 2);
  localparam logic [WORD_W-1:0] WOFS_FAST   = WORD_W'(32'h14 >> 2);
  localparam logic [WORD_W-1:0] WOFS_EVENT  = WORD_W'(32'h18 >> 2);
  localparam logic [WORD_W-1:0] WOFS_RELOAD = WORD_W'(32'h1C >> 2);
  localparam logic [WORD_W-1:0] WOFS_DOWN   = WORD_W'(32'h20 >> 2);
  localparam logic [WORD_W-1:0] WOFS_CTRL   = WORD_W'(32'h4C >> 2);

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_LED,
    SEL_BTN,
    SEL_SLOW,
    SEL_FAST,
    SEL_EVENT,
    SEL_RELOAD,
    SEL_DOWN,
    SEL_CTRL
  } reg_sel_e;

  function automatic reg_sel_e decode_word(input logic [WORD_W-1:0] w);
    reg_sel_e s;
    case (w)
      WOFS_LED:    s = SEL_LED;
      WOFS_BTN:    s = SEL_BTN;
      WOFS_SLOW:   s = SEL_SLOW;
      WOFS_FAST:   s = SEL_FAST;
      WOFS_EVENT:  s = SEL_EVENT;
      WOFS_RELOAD: s = SEL_RELOAD;
      WOFS_DOWN:   s = SEL_DOWN;
      WOFS_CTRL:   s = SEL_CTRL;
      default:     s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/brd_tick_gen.sv
module brd_tick_gen #(
  parameter int unsigned DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic strobe
);

  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] phase_q;
  logic [CW-1:0] phase_d;

  assign strobe = (phase_q == LAST);

  always_comb begin
    if (restart || strobe) phase_d = '0;
    else                   phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

endmodule

// File: rtl/brd_rate_counter.sv
module brd_rate_counter
  import brd_ctrl_pkg::*;
#(
  parameter int unsigned DIV = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] value
);

  logic              step;
  logic              val_en;
  logic [DATA_W-1:0] val_q;
  logic [DATA_W-1:0] val_d;

  brd_tick_gen #(.DIV(DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wr_en),
    .strobe  (step)
  );

  always_comb begin
    val_en = wr_en || step;
    if (wr_en) val_d = wdata;
    else       val_d = val_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= '0;
    else if (val_en) val_q <= val_d;
  end

  assign value = val_q;

  // R7: without a load, the count moves by at most one per cycle
  a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (val_q == $past(val_q)) || (val_q == $past(val_q) + 1'b1));

  // R7: a load lands unchanged
  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> val_q == $past(wdata));

endmodule

// File: rtl/brd_prescale_counter.sv
module brd_prescale_counter
  import brd_ctrl_pkg::*;
#(
  parameter int unsigned DIV = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_reload,
  input  logic              wr_down,
  input  logic              wr_event,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] reload_val,
  output logic [DATA_W-1:0] down_val,
  output logic [DATA_W-1:0] event_val
);

  logic              tick;
  logic              down_zero;
  logic              reload_en, down_en, event_en;
  logic [DATA_W-1:0] reload_q, reload_d;
  logic [DATA_W-1:0] down_q, down_d;
  logic [DATA_W-1:0] event_q, event_d;

  brd_tick_gen #(.DIV(DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (1'b0),
    .strobe  (tick)
  );

  assign down_zero = (down_q == '0);

  always_comb begin
    reload_en = wr_reload;
    reload_d  = wdata;

    down_en = wr_down || tick;
    event_en = wr_event || (tick && down_zero);

    if (wr_down)        down_d = wdata;
    else if (down_zero) down_d = reload_q;
    else                down_d = down_q - 1'b1;

    if (wr_event) event_d = wdata;
    else          event_d = event_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload_q <= '0;
    else if (reload_en) reload_q <= reload_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       down_q <= '0;
    else if (down_en) down_q <= down_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        event_q <= '0;
    else if (event_en) event_q <= event_d;
  end

  assign reload_val = reload_q;
  assign down_val   = down_q;
  assign event_val  = event_q;

  // R8: expiry reloads the down-counter from the reload register
  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && down_zero && !wr_down) |=> down_q == $past(reload_q));

  // R8: expiry bumps the event count
  a_r8_event_bump: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && down_zero && !wr_event) |=> event_q == $past(event_q) + 1'b1);

  // R8: a running down-counter only decrements
  a_r8_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !down_zero && !wr_down) |=> down_q == $past(down_q) - 1'b1);

  // R10: a software load beats the tick
  a_r10_event_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_event |=> event_q == $past(wdata));

endmodule

// File: rtl/brd_ctrl_regs.sv
module brd_ctrl_regs
  import brd_ctrl_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int unsigned PRESC_HZ = 20_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [LED_N-1:0]  led_o
);

  localparam int unsigned SLOW_DIV  = (CLK_HZ > 0) ? CLK_HZ : 1;
  localparam int unsigned FAST_DIV  = (CLK_HZ / 100 > 0) ? CLK_HZ / 100 : 1;
  localparam int unsigned PRESC_DIV = (PRESC_HZ > 0 && CLK_HZ / PRESC_HZ > 0)
                                      ? CLK_HZ / PRESC_HZ : 1;
  localparam int unsigned RATE_N = 2;
  localparam int unsigned RATE_DIV [RATE_N] = '{SLOW_DIV, FAST_DIV};

  // reset: asserted at once, released after two clean edges
  logic [1:0] rst_pipe_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  // decode
  reg_sel_e   sel;
  logic       wr_any;
  logic [1:0] addr_lane_unused;

  assign addr_lane_unused = bus_addr[1:0];
  assign sel    = decode_word(bus_addr[ADDR_W-1:2]);
  assign wr_any = bus_valid && bus_write;

  // LED register
  logic             led_en;
  logic [LED_N-1:0] led_q, led_d;

  always_comb begin
    led_en = wr_any && (sel == SEL_LED);
    led_d  = bus_wdata[LED_N-1:0];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     led_q <= '0;
    else if (led_en) led_q <= led_d;
  end

  assign led_o = led_q;

  // control word
  logic              ctrl_en;
  logic [DATA_W-1:0] ctrl_q, ctrl_d;

  always_comb begin
    ctrl_en = wr_any && (sel == SEL_CTRL);
    ctrl_d  = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  // seconds counters: index 0 slow, index 1 fast
  logic [DATA_W-1:0] rate_val [RATE_N];
  logic [RATE_N-1:0] rate_wr;

  assign rate_wr[0] = wr_any && (sel == SEL_SLOW);
  assign rate_wr[1] = wr_any && (sel == SEL_FAST);

  for (genvar g = 0; g < RATE_N; g++) begin : g_rate
    brd_rate_counter #(.DIV(RATE_DIV[g])) u_rate (
      .clk   (clk),
      .rst_n (rst_sn),
      .wr_en (rate_wr[g]),
      .wdata (bus_wdata),
      .value (rate_val[g])
    );
  end

  // prescaled event counter
  logic [DATA_W-1:0] reload_val, down_val, event_val;

  brd_prescale_counter #(.DIV(PRESC_DIV)) u_presc (
    .clk        (clk),
    .rst_n      (rst_sn),
    .wr_reload  (wr_any && (sel == SEL_RELOAD)),
    .wr_down    (wr_any && (sel == SEL_DOWN)),
    .wr_event   (wr_any && (sel == SEL_EVENT)),
    .wdata      (bus_wdata),
    .reload_val (reload_val),
    .down_val   (down_val),
    .event_val  (event_val)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      case (sel)
        SEL_LED:    bus_rdata = DATA_W'(led_q);
        SEL_SLOW:   bus_rdata = rate_val[0];
        SEL_FAST:   bus_rdata = rate_val[1];
        SEL_EVENT:  bus_rdata = event_val;
        SEL_RELOAD: bus_rdata = reload_val;
        SEL_DOWN:   bus_rdata = down_val;
        SEL_CTRL:   bus_rdata = ctrl_q;
        default:    bus_rdata = '0;
      endcase
    end
  end

  // R2: LED pins follow the two low bits of a write
  a_r2_led_follow: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_valid && bus_write && sel == SEL_LED) |=> led_o == $past(bus_wdata[1:0]));

  // R2 / R5: LED pins hold without an LED write
  a_r5_led_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    !(bus_valid && bus_write && sel == SEL_LED) |=> $stable(led_o));

  // R3: button reads as zero
  a_r3_button_zero: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_valid && !bus_write && sel == SEL_BTN) |-> bus_rdata == '0);

  // R5: unmapped reads return zero
  a_r5_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_valid && !bus_write && sel == SEL_NONE) |-> bus_rdata == '0);

  // R4: the control word changes only when written
  a_r4_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    !(bus_valid && bus_write && sel == SEL_CTRL) |=> $stable(ctrl_q));

endmodule

// File: tb/brd_ctrl_regs_test.sv
module brd_ctrl_regs_test;

  localparam int unsigned T_CLK_HZ   = 1600;
  localparam int unsigned T_PRESC_HZ = 1600;
  localparam int unsigned SLOW_P = 1600;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  led_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  brd_ctrl_regs #(.CLK_HZ(T_CLK_HZ), .PRESC_HZ(T_PRESC_HZ)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .led_o     (led_o)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp_rd;
    logic [1:0]  exp_led;
  } vec_t;

  localparam int VN = 17;
  localparam vec_t VECS [VN] = '{
    '{1'b1, 12'h000, 32'hFFFF_FFFD, 32'h0,         2'b01}, // R2 mask
    '{1'b0, 12'h000, 32'h0,         32'h1,         2'b01}, // R2 readback
    '{1'b1, 12'h000, 32'h0000_0002, 32'h0,         2'b10}, // R2 bit 1
    '{1'b0, 12'h000, 32'h0,         32'h2,         2'b10}, // R2
    '{1'b1, 12'h04C, 32'hA5A5_5A5A, 32'h0,         2'b10}, // R4 store
    '{1'b0, 12'h04C, 32'h0,         32'hA5A5_5A5A, 2'b10}, // R4 read
    '{1'b1, 12'h008, 32'hFFFF_FFFF, 32'h0,         2'b10}, // R3 write
    '{1'b0, 12'h008, 32'h0,         32'h0,         2'b10}, // R3 zero
    '{1'b1, 12'h100, 32'h1234_5678, 32'h0,         2'b10}, // R5 write
    '{1'b0, 12'h100, 32'h0,         32'h0,         2'b10}, // R5 read
    '{1'b0, 12'h04C, 32'h0,         32'hA5A5_5A5A, 2'b10}, // R5 no side effect
    '{1'b0, 12'h04F, 32'h0,         32'hA5A5_5A5A, 2'b10}, // R1 lane bits
    '{1'b1, 12'h003, 32'h0000_0003, 32'h0,         2'b11}, // R1 lane bits
    '{1'b0, 12'h004, 32'h0,         32'h0,         2'b11}, // R5 gap
    '{1'b0, 12'hFFC, 32'h0,         32'h0,         2'b11}, // R5 top word
    '{1'b1, 12'h004, 32'h0000_0000, 32'h0,         2'b11}, // R5 gap write
    '{1'b0, 12'h000, 32'h0,         32'h3,         2'b11}  // R5 LED kept
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drives at the falling edge, samples read data 1 ns later,
  // releases just after the following rising edge
  task automatic do_op(input logic wr, input logic [11:0] a, input logic [31:0] d,
                       output logic [31:0] rd);
    @(negedge clk);
    bus_valid = 1'b1;
    bus_write = wr;
    bus_addr  = a;
    bus_wdata = d;
    #1 rd = bus_rdata;
    @(posedge clk);
    #1 bus_valid = 1'b0;
    bus_write = 1'b0;
  endtask

  task automatic skip(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #80000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    skip(3);
    @(negedge clk) rst_n = 1'b1;
    skip(3);

    // R6: reset state
    chk("R6 led pins", {30'b0, led_o}, 32'h0);
    do_op(1'b0, 12'h000, 32'h0, rd); chk("R6 LED", rd, 32'h0);
    do_op(1'b0, 12'h04C, 32'h0, rd); chk("R6 control", rd, 32'h0);
    do_op(1'b0, 12'h01C, 32'h0, rd); chk("R6 reload", rd, 32'h0);
    do_op(1'b0, 12'h020, 32'h0, rd); chk("R6/R9 down-counter", rd, 32'h0);
    do_op(1'b0, 12'h010, 32'h0, rd); chk("R6 slow count", rd, 32'h0);

    // R2 R3 R4 R5 R1: vector walk
    for (int i = 0; i < VN; i++) begin
      do_op(VECS[i].wr, VECS[i].addr, VECS[i].data, rd);
      if (!VECS[i].wr) chk($sformatf("R1-map vec%0d rdata", i), rd, VECS[i].exp_rd);
      chk($sformatf("R2 vec%0d led", i), {30'b0, led_o}, {30'b0, VECS[i].exp_led});
    end

    // R8 / R10: reload 2, down-counter loaded with 3, event count 100
    do_op(1'b1, 12'h01C, 32'd2, rd);
    do_op(1'b1, 12'h020, 32'd3, rd);
    do_op(1'b1, 12'h018, 32'd100, rd);
    do_op(1'b0, 12'h020, 32'h0, rd); chk("R10 down after load and tick", rd, 32'd2);
    do_op(1'b0, 12'h018, 32'h0, rd); chk("R10 event load", rd, 32'd100);
    do_op(1'b0, 12'h020, 32'h0, rd); chk("R8 down reaches zero", rd, 32'd0);
    do_op(1'b0, 12'h018, 32'h0, rd); chk("R8 event bump on expiry", rd, 32'd101);
    do_op(1'b0, 12'h020, 32'h0, rd); chk("R8 reload then decrement", rd, 32'd1);
    do_op(1'b0, 12'h01C, 32'h0, rd); chk("R8 reload value kept", rd, 32'd2);

    // R9: reload zero
    do_op(1'b1, 12'h01C, 32'd0, rd);
    do_op(1'b1, 12'h020, 32'd0, rd);
    do_op(1'b1, 12'h018, 32'd7, rd);
    do_op(1'b0, 12'h018, 32'h0, rd); chk("R9 event loaded", rd, 32'd7);
    do_op(1'b0, 12'h018, 32'h0, rd); chk("R9 event every tick", rd, 32'd8);
    do_op(1'b0, 12'h018, 32'h0, rd); chk("R9 event every tick", rd, 32'd9);
    do_op(1'b0, 12'h020, 32'h0, rd); chk("R9 down stuck at zero", rd, 32'd0);

    // R7: fast counter, 16-cycle interval
    do_op(1'b1, 12'h014, 32'd50, rd);
    do_op(1'b0, 12'h014, 32'h0, rd); chk("R7 fast load", rd, 32'd50);
    skip(14);
    do_op(1'b0, 12'h014, 32'h0, rd); chk("R7 fast before interval", rd, 32'd50);
    do_op(1'b0, 12'h014, 32'h0, rd); chk("R7 fast at interval", rd, 32'd51);
    skip(15);
    do_op(1'b0, 12'h014, 32'h0, rd); chk("R7 fast second interval", rd, 32'd52);

    // R7: slow counter
    do_op(1'b1, 12'h010, 32'd9, rd);
    skip(SLOW_P - 1);
    do_op(1'b0, 12'h010, 32'h0, rd); chk("R7 slow before interval", rd, 32'd9);
    do_op(1'b0, 12'h010, 32'h0, rd); chk("R7 slow at interval", rd, 32'd10);

    // R6: reset in mid-run
    do_op(1'b1, 12'h04C, 32'hDEAD_BEEF, rd);
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk("R6 led pins in reset", {30'b0, led_o}, 32'h0);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 12'h04C;
    #1 chk("R6 control in reset", bus_rdata, 32'h0);
    bus_addr = 12'h018;
    #1 chk("R6 event in reset", bus_rdata, 32'h0);
    bus_addr = 12'h014;
    #1 chk("R6 fast in reset", bus_rdata, 32'h0);
    bus_valid = 1'b0;

    finish_run();
  end

endmodule